// File: doc/BRIEF.md
# Two-Operand Byte Permute Unit

This block builds a 32-bit word by picking bytes out of a pool of eight. Operand `in_a` supplies pool bytes 0 to 3 and operand `in_b` supplies pool bytes 4 to 7. A selector word and a 3-bit mode code control the pick. The generic mode reads one 4-bit control nibble per result byte from the selector. In each nibble, the low three bits name the pool byte and the top bit turns the result byte into a sign fill. Six shorthand modes take only a 2-bit value from the selector. From that value they build the four nibbles for the common patterns: forward and backward windows, byte broadcast, halfword broadcast, and left and right edge clamping.

One register stage sits between the operands and the result, and valid/ready handshakes sit on both sides. A request is taken on any rising clock edge where `in_valid` and `in_ready` are both high. The result appears on the next edge with `out_valid` set. While `out_ready` is low, the result and `out_valid` are held and `in_ready` is low, so an upstream producer simply waits. When the output register is empty, or is being drained in the same cycle, `in_ready` is high. This lets a request enter every cycle while the downstream side accepts.

Top module: `byte_permute_unit`

## Requirements
- R1: Pool byte k (k = 0..7) is `in_a[8k+7:8k]` for k < 4 and `in_b[8(k-4)+7:8(k-4)]` for k >= 4. In generic mode (code 0), result byte i is pool byte `in_sel[4i+2:4i]` when `in_sel[4i+3]` is 0.
- R2: In generic mode, when `in_sel[4i+3]` is 1, all eight bits of result byte i equal bit 7 of the chosen pool byte.
- R3: In generic mode, `in_sel[31:16]` has no effect. In any shorthand mode, only `in_sel[1:0]` (value V) has an effect, and no result byte is sign-filled.
- R4: Mode code 1 (forward) fills result bytes 0..3 from pool bytes V, V+1, V+2, V+3.
- R5: Mode code 2 (backward) fills result bytes 0..3 from pool bytes V, (V-1) mod 8, (V-2) mod 8, (V-3) mod 8.
- R6: Mode code 3 (byte broadcast) fills all four result bytes from pool byte V.
- R7: Mode code 4 (left clamp) fills result bytes 0..3 from pool bytes V, max(V,1), max(V,2), 3.
- R8: Mode code 5 (right clamp) fills result bytes 0..3 from pool bytes 0, min(V,1), min(V,2), V.
- R9: Mode code 6 (halfword broadcast) uses W = 2*(V mod 2) and fills result bytes 0..3 from pool bytes W, W+1, W, W+1.
- R10: Mode code 7 behaves exactly like generic mode.
- R11: A request taken on a clock edge sets `out_valid` after that edge, with the result of that request on `out_data`. While `out_valid` is high and `out_ready` is low, both `out_valid` and `out_data` stay unchanged.
- R12: A synchronous active-high `rst` clears `out_valid` on the next clock edge.
- R13: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. This allows one request per cycle under full downstream acceptance, and no request is taken while the output is stalled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| in_a | input | 32 | Operand supplying pool bytes 0..3 |
| in_b | input | 32 | Operand supplying pool bytes 4..7 |
| in_sel | input | 32 | Selector nibbles or shorthand value |
| in_mode | input | 3 | Mode code 0..7 |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Downstream takes the result |
| out_data | output | 32 | Permuted result |

## Verification
The bench drives generic selectors that reach into the upper operand, reverse the bytes, and mix sign-filled and plain lanes. It does this with pool bytes whose top bits differ, so a sign fill taken from the wrong byte or bit gives a wrong value. It sets the unused upper selector bits, and the sign bits under shorthand modes, to nonzero values; a decoder that let them through would change the result. The backward mode is run at V = 0 and V = 2 to check that indices wrap into the b operand rather than saturating. The clamp and halfword modes are run at all four V values, because an off-by-one edge rule fails at only one of them. Back-pressure, back-to-back traffic and a mid-stream reset reveal a stage that overwrites a held result, loses throughput, or keeps a stale valid.

// File: rtl/bperm_pkg.sv
package bperm_pkg;
  localparam int unsigned LANES  = 4;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned IDX_W  = 3;
  localparam int unsigned NIB_W  = IDX_W + 1;
  localparam int unsigned WORD_W = LANES * BYTE_W;
  localparam int unsigned POOL_W = 2 * WORD_W;
  localparam int unsigned SEL_W  = LANES * NIB_W;

  typedef enum logic [2:0] {
    MODE_GENERIC = 3'd0,
    MODE_FWD     = 3'd1,
    MODE_BWD     = 3'd2,
    MODE_REP8    = 3'd3,
    MODE_CLAMP_L = 3'd4,
    MODE_CLAMP_R = 3'd5,
    MODE_REP16   = 3'd6,
    MODE_ALT_GEN = 3'd7
  } perm_mode_e;

  typedef struct packed {
    logic             fill;
    logic [IDX_W-1:0] idx;
  } lane_sel_t;
endpackage

// File: rtl/bperm_sel_expand.sv
module bperm_sel_expand
  import bperm_pkg::*;
(
  input  perm_mode_e                 mode,
  input  logic [SEL_W-1:0]           sel,
  output lane_sel_t [LANES-1:0]      lanes
);
  logic [IDX_W-1:0] v;

  always_comb begin
    v = {1'b0, sel[1:0]};
    for (int k = 0; k < LANES; k++) begin
      lanes[k] = lane_sel_t'(sel[k*NIB_W +: NIB_W]);
    end
    case (mode)
      MODE_FWD: begin
        for (int k = 0; k < LANES; k++) lanes[k] = '{fill: 1'b0, idx: v + IDX_W'(k)};
      end
      MODE_BWD: begin
        for (int k = 0; k < LANES; k++) lanes[k] = '{fill: 1'b0, idx: v - IDX_W'(k)};
      end
      MODE_REP8: begin
        for (int k = 0; k < LANES; k++) lanes[k] = '{fill: 1'b0, idx: v};
      end
      MODE_CLAMP_L: begin
        lanes[0] = '{fill: 1'b0, idx: v};
        lanes[1] = '{fill: 1'b0, idx: (v < 3'd1) ? 3'd1 : v};
        lanes[2] = '{fill: 1'b0, idx: (v < 3'd2) ? 3'd2 : v};
        lanes[3] = '{fill: 1'b0, idx: 3'd3};
      end
      MODE_CLAMP_R: begin
        lanes[0] = '{fill: 1'b0, idx: 3'd0};
        lanes[1] = '{fill: 1'b0, idx: (v > 3'd1) ? 3'd1 : v};
        lanes[2] = '{fill: 1'b0, idx: (v > 3'd2) ? 3'd2 : v};
        lanes[3] = '{fill: 1'b0, idx: v};
      end
      MODE_REP16: begin
        for (int k = 0; k < LANES; k++) lanes[k] = '{fill: 1'b0, idx: {1'b0, sel[0], 1'(k)}};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bperm_lane_pick.sv
module bperm_lane_pick
  import bperm_pkg::*;
(
  input  logic [POOL_W-1:0] pool,
  input  lane_sel_t         ctl,
  output logic [BYTE_W-1:0] lane_out
);
  logic [BYTE_W-1:0] picked;

  always_comb begin
    picked   = pool[ctl.idx*BYTE_W +: BYTE_W];
    lane_out = ctl.fill ? {BYTE_W{picked[BYTE_W-1]}} : picked;
  end
endmodule

// File: rtl/bperm_out_stage.sv
module bperm_out_stage #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         up_valid,
  output logic         up_ready,
  input  logic [W-1:0] up_data,
  output logic         dn_valid,
  input  logic         dn_ready,
  output logic [W-1:0] dn_data
);
  logic         vld_q;
  logic [W-1:0] data_q;

  assign up_ready = !vld_q || dn_ready;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else if (up_ready) vld_q <= up_valid;
  end

  always_ff @(posedge clk) begin
    if (up_valid && up_ready) data_q <= up_data;
  end

  assign dn_valid = vld_q;
  assign dn_data  = data_q;
endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bperm_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_a,
  input  logic [WORD_W-1:0] in_b,
  input  logic [WORD_W-1:0] in_sel,
  input  logic [2:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data
);
  lane_sel_t [LANES-1:0] lane_ctl;
  logic [POOL_W-1:0]     pool;
  logic [WORD_W-1:0]     result;
  logic                  unused_sel_hi;

  assign pool          = {in_b, in_a};
  assign unused_sel_hi = ^in_sel[WORD_W-1:SEL_W];

  bperm_sel_expand u_expand (
    .mode  (perm_mode_e'(in_mode)),
    .sel   (in_sel[SEL_W-1:0]),
    .lanes (lane_ctl)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    bperm_lane_pick u_pick (
      .pool     (pool),
      .ctl      (lane_ctl[g]),
      .lane_out (result[g*BYTE_W +: BYTE_W])
    );
  end

  bperm_out_stage #(.W(WORD_W)) u_stage (
    .clk      (clk),
    .rst      (rst),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (result),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (out_data)
  );
endmodule

// File: rtl/byte_permute_chk.sv
module byte_permute_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data
);
  // R11
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R11
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_data));

  // R11
  take_sets_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R12
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> !out_valid);

  // R13
  stall_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R13
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> in_ready);
endmodule

bind byte_permute_unit byte_permute_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/test_byte_permute_unit.sv
module test_byte_permute_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;
  localparam logic [31:0] OPA = 32'h448322F1; // pool 0..3: F1 22 83 44
  localparam logic [31:0] OPB = 32'h7FA506C0; // pool 4..7: C0 06 A5 7F

  localparam logic [2:0] V_MODE [NV] = '{
    3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd7,
    3'd1, 3'd1, 3'd1, 3'd2, 3'd2, 3'd2, 3'd3, 3'd3,
    3'd4, 3'd4, 3'd4, 3'd4, 3'd5, 3'd5, 3'd5, 3'd5,
    3'd6, 3'd6, 3'd6, 3'd6};
  localparam logic [31:0] V_SEL [NV] = '{
    32'h00003210, 32'h00007654, 32'h00000123, 32'h00008888, 32'h0000C9A1, 32'hDEAD3210, 32'h00007654,
    32'h00000000, 32'h00000001, 32'hFFFFFFF7, 32'h00000000, 32'h00000002, 32'h00000003,
    32'h00000001, 32'h0000FFFE,
    32'h00000000, 32'h00000001, 32'h00000002, 32'h00000003,
    32'h00000000, 32'h00000001, 32'h00000002, 32'h00000003,
    32'h00000000, 32'h00000001, 32'h00000002, 32'hABCDEF0B};
  localparam logic [31:0] V_EXP [NV] = '{
    32'h448322F1, 32'h7FA506C0, 32'hF1228344, 32'hFFFFFFFF, 32'hFF00FF22, 32'h448322F1, 32'h7FA506C0,
    32'h448322F1, 32'hC0448322, 32'hA506C044, 32'h06A57FF1, 32'h7FF12283, 32'hF1228344,
    32'h22222222, 32'h83838383,
    32'h448322F1, 32'h44832222, 32'h44838383, 32'h44444444,
    32'hF1F1F1F1, 32'h222222F1, 32'h838322F1, 32'h448322F1,
    32'h22F122F1, 32'h44834483, 32'h22F122F1, 32'h44834483};
  // Tags per entry: 0-2 R1, 3-4 R2, 5 R3, 6 R10, 7-9 R4 (9 also R3), 10-12 R5,
  // 13-14 R6 (14 also R3), 15-18 R7, 19-22 R8, 23-26 R9 (26 also R3)
  localparam int V_REQ [NV] = '{1, 1, 1, 2, 2, 3, 10, 4, 4, 4, 5, 5, 5, 6, 6,
                                7, 7, 7, 7, 8, 8, 8, 8, 9, 9, 9, 9};

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [31:0] in_sel = '0;
  logic [2:0]  in_mode = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_data;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  byte_permute_unit i_byte_permute_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sel(in_sel), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input int k);
    in_a = OPA; in_b = OPB; in_mode = V_MODE[k]; in_sel = V_SEL[k];
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R13 reset in_ready", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;

    // Vector table: one request, sampled one edge later
    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      load(k); in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vector %0d", V_REQ[k], k), out_data, V_EXP[k]);
      check("R11 out_valid after take", {31'd0, out_valid}, 32'd1);
    end

    // R11 / R13: back-pressure holds the result and refuses a new request
    @(negedge clk);
    out_ready = 1'b0; load(0); in_valid = 1'b1;
    @(negedge clk);
    load(1);
    for (int c = 0; c < 3; c++) begin
      check("R13 in_ready low while stalled", {31'd0, in_ready}, 32'd0);
      check("R11 held data", out_data, V_EXP[0]);
      check("R11 held valid", {31'd0, out_valid}, 32'd1);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R13 stalled request not taken", {31'd0, out_valid}, 32'd0);

    // R13: back-to-back requests with full acceptance
    load(8); in_valid = 1'b1;
    @(negedge clk);
    check("R13 first of pair", out_data, V_EXP[8]);
    load(10);
    @(negedge clk);
    check("R13 second of pair", out_data, V_EXP[10]);
    check("R13 second valid", {31'd0, out_valid}, 32'd1);
    in_valid = 1'b0;
    @(negedge clk);
    check("R11 drained", {31'd0, out_valid}, 32'd0);

    // R12: reset in the middle of a stall
    out_ready = 1'b0; load(13); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    check("R12 mid-stream reset", {31'd0, out_valid}, 32'd0);
    rst = 1'b0; out_ready = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule